// File: doc/BRIEF.md
# Address Region Attribute Unit

The unit holds a small set of programmable physical-address windows and, for each address presented on its lookup port, reports the memory type that applies: uncacheable, write-combining, write-through or write-back. Each window is described by a base address, a 4-bit size code and a control byte. The window with the highest number has a coarser size unit and its own control-byte encoding. In that encoding bit 0 means cache enable, where in the other windows it means cache disable.

Software programs the windows through a byte-wide index/data configuration port. A configuration control register is always reachable. One bit in it opens the window registers to access. While that bit is clear, reads of window indices return all ones and writes to them are dropped. The lookup result is registered: the type for an address driven in one cycle appears after the next rising edge. That result is computed from the window settings that held before any configuration write in the same cycle.

Top module: `addr_region_unit`

## Requirements
- R1: Window n (0..7) occupies the three indices 0xC4+3n, 0xC5+3n and 0xC6+3n. The first byte holds base address bits 31:24 and the second holds bits 23:16. The third holds bits 15:12 in its upper nibble and the size code in its lower nibble. All three read back what was written.
- R2: The control byte of window n sits at index 0xDC+n and reads back what was written.
- R3: The configuration control register at index 0xC3 can always be written and read. Its bit 4 is the map-enable bit.
- R4: While the map-enable bit is 0, a read of any index from 0xC4 to 0xE3 returns 0xFF and a write to those indices leaves the register unchanged. A read of any unassigned index returns 0xFF.
- R5: After reset every window byte, control byte and the configuration control register are 0. The lookup outputs show a miss: miss_o is 1, mem_type_o is write-back (3) and hit_idx_o is 0.
- R6: A window with size code 0 or 15 never matches.
- R7: For windows 0..6 with size code c in 1..14, the window covers 4 KiB·2^(c-1) bytes. An address matches when its bits from log2(size) upward equal the same base bits, so base bits below the size are ignored.
- R8: For window 7 with size code c in 1..14, the window covers 256 KiB·2^(c-1) bytes, with the same aligned match rule as R7.
- R9: For windows 0..6 the control byte maps 1 to uncacheable, 8 to write-back and 9 to write-combining. Every other value, 24 included, maps to write-through.
- R10: For window 7 the control byte maps 0 to uncacheable, 8 to write-combining and 9 to write-back. Every other value, 25 included, maps to write-through.
- R11: When more than one enabled window matches, the lowest-numbered one sets mem_type_o and hit_idx_o.
- R12: When no window matches, miss_o is 1, mem_type_o is write-back and hit_idx_o is 0. On a match miss_o is 0. mem_type_o encodes 0 = uncacheable, 1 = write-combining, 2 = write-through, 3 = write-back.
- R13: Lookup outputs change one rising edge after addr_i is presented. They reflect the configuration as it stood before a configuration write taking effect on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 8 | Configuration index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_idx_i, combinational |
| addr_i | input | 32 | Physical address to classify |
| mem_type_o | output | 2 | Memory type of the registered lookup |
| miss_o | output | 1 | No enabled window matched |
| hit_idx_o | output | 3 | Number of the winning window |

## Verification
A configuration write and a lookup can land on the same clock edge. The write can retarget, resize or disable the window that the lookup is about to hit. The bench drives a window-changing write and an address inside that window in the same cycle. It expects the result from the settings before the write, then checks the next lookup of that address against the settings after it. Random passes mix configuration writes with lookups at addresses near the programmed bases. Every result is compared with a bench model that is updated only after each write edge.

// File: rtl/arau_pkg.sv
package arau_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    MT_UC = 2'd0,
    MT_WC = 2'd1,
    MT_WT = 2'd2,
    MT_WB = 2'd3
  } mem_type_e;

  typedef struct packed {
    logic [19:0] base;   // address bits 31:12
    logic [3:0]  code;
    logic [7:0]  ctrl;
  } region_cfg_t;

  function automatic mem_type_e decode_ctrl(input logic [7:0] c, input logic wide);
    mem_type_e t;
    if (!wide) begin
      case (c)
        8'd1:    t = MT_UC;
        8'd8:    t = MT_WB;
        8'd9:    t = MT_WC;
        default: t = MT_WT;
      endcase
    end else begin
      case (c)
        8'd0:    t = MT_UC;
        8'd8:    t = MT_WC;
        8'd9:    t = MT_WB;
        default: t = MT_WT;
      endcase
    end
    return t;
  endfunction
endpackage

// File: rtl/arau_cfg_port.sv
module arau_cfg_port
  import arau_pkg::*;
#(
  parameter int NUM_REGIONS     = 8,
  parameter int REGION_BASE_IDX = 'hC4,
  parameter int CTRL_BASE_IDX   = 'hDC,
  parameter int CFG_CTRL_IDX    = 'hC3,
  parameter int MAP_EN_BIT      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_idx_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  output logic        map_en_o,
  output region_cfg_t regions_o [NUM_REGIONS]
);
  localparam int NBYTES = NUM_REGIONS * 3;

  logic [7:0] rbyte_q [NBYTES];
  logic [7:0] ctrl_q  [NUM_REGIONS];
  logic [7:0] ccr_q;

  assign map_en_o = ccr_q[MAP_EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccr_q <= '0;
      for (int k = 0; k < NBYTES; k++) rbyte_q[k] <= '0;
      for (int k = 0; k < NUM_REGIONS; k++) ctrl_q[k] <= '0;
    end else if (cfg_we_i) begin
      if (cfg_idx_i == 8'(CFG_CTRL_IDX)) ccr_q <= cfg_wdata_i;
      if (map_en_o) begin
        for (int k = 0; k < NBYTES; k++)
          if (cfg_idx_i == 8'(REGION_BASE_IDX + k)) rbyte_q[k] <= cfg_wdata_i;
        for (int k = 0; k < NUM_REGIONS; k++)
          if (cfg_idx_i == 8'(CTRL_BASE_IDX + k)) ctrl_q[k] <= cfg_wdata_i;
      end
    end
  end

  always_comb begin
    cfg_rdata_o = 8'hFF;
    if (cfg_idx_i == 8'(CFG_CTRL_IDX)) cfg_rdata_o = ccr_q;
    if (map_en_o) begin
      for (int k = 0; k < NBYTES; k++)
        if (cfg_idx_i == 8'(REGION_BASE_IDX + k)) cfg_rdata_o = rbyte_q[k];
      for (int k = 0; k < NUM_REGIONS; k++)
        if (cfg_idx_i == 8'(CTRL_BASE_IDX + k)) cfg_rdata_o = ctrl_q[k];
    end
  end

  for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_out
    assign regions_o[n].base = {rbyte_q[3*n], rbyte_q[3*n+1], rbyte_q[3*n+2][7:4]};
    assign regions_o[n].code = rbyte_q[3*n+2][3:0];
    assign regions_o[n].ctrl = ctrl_q[n];
  end
endmodule

// File: rtl/arau_region_match.sv
module arau_region_match
  import arau_pkg::*;
#(
  parameter bit WIDE     = 1'b0,
  parameter int UNIT_LOG = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  region_cfg_t       cfg_i,
  output logic              hit_o,
  output mem_type_e         type_o
);
  // size = 2^UNIT_LOG * 2^(code-1)
  localparam logic [5:0] SH_OFS = 6'(UNIT_LOG - 1);

  logic [5:0]        shift;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] base_full;
  logic              enabled;

  assign enabled   = (cfg_i.code != 4'h0) && (cfg_i.code != 4'hF);
  assign shift     = SH_OFS + {2'b00, cfg_i.code};
  assign mask      = {ADDR_W{1'b1}} << shift;
  assign base_full = {cfg_i.base, 12'h000};
  assign hit_o     = enabled && (((addr_i ^ base_full) & mask) == '0);
  assign type_o    = decode_ctrl(cfg_i.ctrl, WIDE);
endmodule

// File: rtl/arau_prio_sel.sv
module arau_prio_sel
  import arau_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int HIT_W      = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  input  mem_type_e              type_i [NUM_REGIONS],
  output logic                   any_o,
  output logic [HIT_W-1:0]       idx_o,
  output mem_type_e              type_o
);
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    type_o = MT_WB;
    for (int k = NUM_REGIONS - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        any_o  = 1'b1;
        idx_o  = HIT_W'(k);
        type_o = type_i[k];
      end
    end
  end
endmodule

// File: rtl/addr_region_unit.sv
module addr_region_unit
  import arau_pkg::*;
#(
  parameter int NUM_REGIONS     = 8,
  parameter int REGION_BASE_IDX = 'hC4,
  parameter int CTRL_BASE_IDX   = 'hDC,
  parameter int CFG_CTRL_IDX    = 'hC3,
  parameter int MAP_EN_BIT      = 4,
  parameter int NARROW_UNIT_LOG = 12,
  parameter int WIDE_UNIT_LOG   = 18,
  localparam int HIT_W          = $clog2(NUM_REGIONS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_idx_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [1:0]        mem_type_o,
  output logic              miss_o,
  output logic [HIT_W-1:0]  hit_idx_o
);
  region_cfg_t            regions [NUM_REGIONS];
  logic                   map_en;
  logic [NUM_REGIONS-1:0] hit;
  mem_type_e              rtype [NUM_REGIONS];
  logic                   any_hit;
  logic [HIT_W-1:0]       win_idx;
  mem_type_e              win_type;

  arau_cfg_port #(
    .NUM_REGIONS    (NUM_REGIONS),
    .REGION_BASE_IDX(REGION_BASE_IDX),
    .CTRL_BASE_IDX  (CTRL_BASE_IDX),
    .CFG_CTRL_IDX   (CFG_CTRL_IDX),
    .MAP_EN_BIT     (MAP_EN_BIT)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o),
    .map_en_o   (map_en),
    .regions_o  (regions)
  );

  // last window uses the coarse unit and its own control encoding
  for (genvar n = 0; n < NUM_REGIONS; n++) begin : g_win
    if (n == NUM_REGIONS - 1) begin : g_wide
      arau_region_match #(.WIDE(1'b1), .UNIT_LOG(WIDE_UNIT_LOG)) u_match (
        .addr_i(addr_i), .cfg_i(regions[n]), .hit_o(hit[n]), .type_o(rtype[n])
      );
    end else begin : g_narrow
      arau_region_match #(.WIDE(1'b0), .UNIT_LOG(NARROW_UNIT_LOG)) u_match (
        .addr_i(addr_i), .cfg_i(regions[n]), .hit_o(hit[n]), .type_o(rtype[n])
      );
    end
  end

  arau_prio_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
    .hit_i (hit),
    .type_i(rtype),
    .any_o (any_hit),
    .idx_o (win_idx),
    .type_o(win_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_type_o <= MT_WB;
      miss_o     <= 1'b1;
      hit_idx_o  <= '0;
    end else begin
      mem_type_o <= win_type;
      miss_o     <= !any_hit;
      hit_idx_o  <= win_idx;
    end
  end
endmodule

// File: rtl/arau_checker.sv
module arau_checker #(
  parameter int NUM_REGIONS     = 8,
  parameter int REGION_BASE_IDX = 'hC4,
  parameter int CTRL_BASE_IDX   = 'hDC,
  parameter int CFG_CTRL_IDX    = 'hC3,
  parameter int MAP_EN_BIT      = 4,
  localparam int HIT_W          = $clog2(NUM_REGIONS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_idx_i,
  input logic [7:0]       cfg_wdata_i,
  input logic [7:0]       cfg_rdata_o,
  input logic             map_en,
  input logic [1:0]       mem_type_o,
  input logic             miss_o,
  input logic [HIT_W-1:0] hit_idx_o
);
  localparam logic [7:0] LOCK_LO = 8'(REGION_BASE_IDX);
  localparam logic [7:0] LOCK_HI = 8'(CTRL_BASE_IDX + NUM_REGIONS - 1);

  logic in_locked;
  assign in_locked = (cfg_idx_i >= LOCK_LO) && (cfg_idx_i <= LOCK_HI);

  // R4
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_locked && !map_en) |-> (cfg_rdata_o == 8'hFF));

  // R3
  map_en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == 8'(CFG_CTRL_IDX)) |=> (map_en == $past(cfg_wdata_i[MAP_EN_BIT])));

  // R12
  miss_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (mem_type_o == 2'd3));

  // R12
  miss_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (hit_idx_o == '0));

  // R3
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_idx_i == 8'(CFG_CTRL_IDX)) ##1 (cfg_idx_i == 8'(CFG_CTRL_IDX))
      |-> (cfg_rdata_o == $past(cfg_wdata_i)));
endmodule

bind addr_region_unit arau_checker #(
  .NUM_REGIONS    (NUM_REGIONS),
  .REGION_BASE_IDX(REGION_BASE_IDX),
  .CTRL_BASE_IDX  (CTRL_BASE_IDX),
  .CFG_CTRL_IDX   (CFG_CTRL_IDX),
  .MAP_EN_BIT     (MAP_EN_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_idx_i  (cfg_idx_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o),
  .map_en     (map_en),
  .mem_type_o (mem_type_o),
  .miss_o     (miss_o),
  .hit_idx_o  (hit_idx_o)
);

// File: tb/addr_region_unit_test.sv
module addr_region_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_idx_i = 8'h00;
  logic [7:0]  cfg_wdata_i = 8'h00;
  logic [7:0]  cfg_rdata_o;
  logic [31:0] addr_i = 32'h0;
  logic [1:0]  mem_type_o;
  logic        miss_o;
  logic [2:0]  hit_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_rb [24];
  logic [7:0] m_rc [8];
  logic [7:0] m_ccr;

  always #4 clk_i = ~clk_i;

  addr_region_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o), .addr_i(addr_i),
    .mem_type_o(mem_type_o), .miss_o(miss_o), .hit_idx_o(hit_idx_o)
  );

  function automatic logic [1:0] exp_type(input logic [7:0] c, input bit wide);
    if (!wide) begin
      if (c == 8'd1) return 2'd0;
      if (c == 8'd8) return 2'd3;
      if (c == 8'd9) return 2'd1;
      return 2'd2;
    end
    if (c == 8'd0) return 2'd0;
    if (c == 8'd8) return 2'd1;
    if (c == 8'd9) return 2'd3;
    return 2'd2;
  endfunction

  // {miss, idx[2:0], type[1:0]}
  function automatic logic [5:0] exp_lookup(input logic [31:0] a);
    for (int n = 0; n < 8; n++) begin
      logic [3:0]  code;
      logic [31:0] base;
      logic [31:0] msk;
      int          sh;
      code = m_rb[3*n+2][3:0];
      if (code == 4'h0 || code == 4'hF) continue;
      sh   = ((n == 7) ? 17 : 11) + int'(code);
      msk  = 32'hFFFF_FFFF << sh;
      base = {m_rb[3*n], m_rb[3*n+1], m_rb[3*n+2][7:4], 12'h000};
      if (((a ^ base) & msk) == 32'h0) return {1'b0, 3'(n), exp_type(m_rc[n], n == 7)};
    end
    return {1'b1, 3'd0, 2'd3};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] idx);
    if (idx == 8'hC3) return m_ccr;
    if (m_ccr[4] && idx >= 8'hC4 && idx <= 8'hDB) return m_rb[idx - 8'hC4];
    if (m_ccr[4] && idx >= 8'hDC && idx <= 8'hE3) return m_rc[idx - 8'hDC];
    return 8'hFF;
  endfunction

  function automatic void model_write(input logic [7:0] idx, input logic [7:0] d);
    if (idx >= 8'hC4 && idx <= 8'hDB && m_ccr[4]) m_rb[idx - 8'hC4] = d;
    if (idx >= 8'hDC && idx <= 8'hE3 && m_ccr[4]) m_rc[idx - 8'hDC] = d;
    if (idx == 8'hC3) m_ccr = d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    model_write(idx, d);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] idx);
    @(negedge clk_i);
    cfg_idx_i = idx;
    #1;
    check(tag, {24'h0, cfg_rdata_o}, {24'h0, exp_read(idx)});
  endtask

  task automatic look_chk(input string tag, input logic [31:0] a);
    logic [5:0] e;
    @(negedge clk_i);
    addr_i = a;
    e = exp_lookup(a);
    @(posedge clk_i); #1;
    check(tag, {26'h0, miss_o, hit_idx_o, mem_type_o}, {26'h0, e});
  endtask

  task automatic set_region(input int n, input logic [31:0] base, input logic [3:0] code,
                            input logic [7:0] ctl);
    wr(8'(8'hC4 + 3*n), base[31:24]);
    wr(8'(8'hC5 + 3*n), base[23:16]);
    wr(8'(8'hC6 + 3*n), {base[15:12], code});
    wr(8'(8'hDC + n), ctl);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [5:0] e;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 24; k++) m_rb[k] = 8'h0;
    for (int k = 0; k < 8; k++) m_rc[k] = 8'h0;
    m_ccr = 8'h0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R5 reset state
    #1 check("R5 reset outputs", {29'h0, miss_o, mem_type_o}, {29'h0, 1'b1, 2'd3});
    check("R5 reset idx", {29'h0, hit_idx_o}, 32'h0);
    rd_chk("R5 R3 reset ctrl reg", 8'hC3);
    look_chk("R5 lookup after reset", 32'h0000_0000);

    // R4 locked access
    rd_chk("R4 locked region read", 8'hC6);
    rd_chk("R4 locked ctrl read", 8'hE3);
    rd_chk("R4 unassigned read", 8'h10);
    wr(8'hC6, 8'h35);
    wr(8'hDC, 8'h09);
    wr(8'hC3, 8'h10);
    rd_chk("R3 map enable set", 8'hC3);
    rd_chk("R4 write ignored region", 8'hC6);
    rd_chk("R4 write ignored ctrl", 8'hDC);
    look_chk("R4 ignored write no match", 32'h0000_0000);

    // R1 R2 readback
    set_region(2, 32'hABCD_E000, 4'h7, 8'd24);
    rd_chk("R1 byte0", 8'hCA);
    rd_chk("R1 byte1", 8'hCB);
    rd_chk("R1 byte2", 8'hCC);
    rd_chk("R2 ctrl", 8'hDE);
    set_region(2, 32'h0, 4'h0, 8'd0);

    // R7 granularity and alignment
    set_region(0, 32'h0001_0000, 4'h1, 8'd1);
    look_chk("R7 4K top hit", 32'h0001_0FFF);
    look_chk("R7 4K past end", 32'h0001_1000);
    look_chk("R7 4K below", 32'h0000_FFFF);
    set_region(0, 32'h0002_3000, 4'h3, 8'd1);
    look_chk("R7 unaligned base", 32'h0002_0000);
    look_chk("R7 16K end", 32'h0002_4000);
    set_region(0, 32'h0000_0000, 4'hE, 8'd1);
    look_chk("R7 32M top", 32'h01FF_FFFF);
    look_chk("R7 32M past", 32'h0200_0000);

    // R9 narrow decode
    foreach (m_rc[k]) if (k == 0) begin end
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c;
      c = (v == 0) ? 8'd1 : (v == 1) ? 8'd8 : (v == 2) ? 8'd9 : (v == 3) ? 8'd24 :
          (v == 4) ? 8'd0 : 8'd25;
      wr(8'hDC, c);
      look_chk($sformatf("R9 narrow ctrl %0d", c), 32'h0000_1000);
    end

    // R8 wide granularity, R10 wide decode
    set_region(0, 32'h0, 4'h0, 8'd0);
    set_region(7, 32'h0040_0000, 4'h1, 8'd0);
    look_chk("R8 256K top", 32'h0043_FFFF);
    look_chk("R8 256K past", 32'h0044_0000);
    set_region(7, 32'h8000_0000, 4'hE, 8'd0);
    look_chk("R8 2G hit", 32'hFFFF_FFFF);
    look_chk("R8 2G miss", 32'h7FFF_FFFF);
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c;
      c = (v == 0) ? 8'd0 : (v == 1) ? 8'd8 : (v == 2) ? 8'd9 : (v == 3) ? 8'd25 :
          (v == 4) ? 8'd1 : 8'd24;
      wr(8'hE3, c);
      look_chk($sformatf("R10 wide ctrl %0d", c), 32'h9000_0000);
    end
    set_region(7, 32'h0, 4'h0, 8'd0);

    // R6 code 15
    set_region(4, 32'h0000_0000, 4'hF, 8'd1);
    look_chk("R6 code 15 disabled", 32'h0000_0000);
    set_region(4, 32'h0000_0000, 4'h0, 8'd1);

    // R11 priority
    set_region(3, 32'h0100_0000, 4'h8, 8'd1);
    set_region(1, 32'h0100_0000, 4'h4, 8'd9);
    look_chk("R11 lower wins", 32'h0100_1000);
    look_chk("R11 only higher", 32'h0102_0000);

    // R13 write and lookup in the same cycle
    @(negedge clk_i);
    addr_i = 32'h0100_1000; cfg_we_i = 1'b1; cfg_idx_i = 8'hC9; cfg_wdata_i = 8'h00;
    e = exp_lookup(32'h0100_1000);
    @(posedge clk_i); #1;
    cfg_we_i = 1'b0;
    model_write(8'hC9, 8'h00);
    check("R13 same cycle uses old config", {26'h0, miss_o, hit_idx_o, mem_type_o}, {26'h0, e});
    look_chk("R13 next cycle uses new config", 32'h0100_1000);

    // lock again, then lookups still work, writes dropped
    wr(8'hC3, 8'h00);
    wr(8'hCF, 8'h00);
    look_chk("R4 locked write kept region", 32'h0100_0000);
    wr(8'hC3, 8'h1F);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int n;
      logic [31:0] b;
      logic [7:0]  ctl;
      logic [7:0]  pick [6];
      pick = '{8'd0, 8'd1, 8'd8, 8'd9, 8'd24, 8'd25};
      n   = int'($urandom_range(0, 7));
      b   = $urandom & 32'h0FFF_F000;
      ctl = pick[$urandom_range(0, 5)];
      set_region(n, b, 4'($urandom_range(0, 15)), ctl);
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a;
        int r;
        r = int'($urandom_range(0, 7));
        a = {m_rb[3*r], m_rb[3*r+1], m_rb[3*r+2][7:4], 12'h000} ^ ($urandom & 32'h0003_FFFF);
        if (j == 5) a = $urandom;
        look_chk("R7 R8 R9 R10 R11 R12 random", a);
      end
      rd_chk("R1 R2 random readback", 8'(8'hC4 + $urandom_range(0, 31)));
    end

    done = 1'b1;
    finish_run();
  end
endmodule